// File: doc/BRIEF.md
# Bus-Shared Bidirectional Port Controller

This block controls a 16-bit bidirectional pin group built from two 8-bit lanes. Every pin has an output latch, a direction bit and an input path. In general-purpose operation, software on the internal register interface writes the latches and the direction bits, and it reads the pins through a two-flop synchronizer. A direction bit of 1 makes a pin an output.

An external bus controller can claim the pins by selecting one of four bus layouts. For every lane it owns, the controller takes over the latch input and the pin direction. The latch is reloaded from the alternate output word, and the output enable follows the controller's drive request. The pin values are handed back on a separate alternate input word.

In the multiplexed layouts the address goes out first and the data follows. In the 8-bit multiplexed layout the high lane carries the upper address byte for the whole access. In the 8-bit demultiplexed layout only the low lane is taken, and the high lane stays general-purpose. When the bus layout is switched off, the direction values that software last wrote take effect again.

Top module: `bus_port_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, all latches and direction bits are 0, so that pad_out=0, pad_oe=0, wr_dropped=0 and a direction read returns 0.
- R2: In general-purpose mode (bus_mode=0), a write with reg_addr=0 loads reg_wdata into each lane whose reg_wbe bit is set (bit 0 selects pins 7..0, bit 1 selects pins 15..8). pad_out shows the new value after that clock edge, and pad_oe equals the direction register, where 1 means drive.
- R3: A read with reg_addr=0 returns pad_in through two flops, so a pad value present at clock edge k is returned after edge k+1.
- R4: A write with reg_addr=1 always stores into the direction register, and a read with reg_addr=1 returns the stored value even while the bus owns the pins. When a lane leaves bus ownership, its pad_oe equals the stored direction again.
- R5: In 16-bit multiplexed mode (bus_mode=4), both lanes load alt_dout on every edge and drive pad_oe equal to bc_oe on all pins.
- R6: In 8-bit multiplexed mode (bus_mode=3), the low lane behaves as in R5. The high lane loads alt_dout[15:8] only on an edge where alt_addr_phase=1, holds its value otherwise, and drives pad_oe=1 on all its pins.
- R7: In 16-bit demultiplexed mode (bus_mode=2), both lanes load alt_dout on every edge and pad_oe follows bc_oe.
- R8: In 8-bit demultiplexed mode (bus_mode=1), the low lane is bus-owned as in R7. The high lane takes software latch writes and uses its direction bits exactly as in R2.
- R9: A latch write (reg_addr=0) to a bus-owned lane leaves that lane's latch untouched. wr_dropped is 1 for exactly the cycle after the write edge. Lanes of the same write that are not owned are still written.
- R10: alt_din equals pad_in on the pins of bus-owned lanes and is 0 on the other pins, with no clock delay.
- R11: bus_mode values 5, 6 and 7 behave exactly as general-purpose mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = latch/pin data, 1 = direction |
| reg_wbe | input | 2 | Lane write enables (bit 0 low lane) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| wr_dropped | output | 1 | One-cycle flag: a latch write hit a bus-owned lane |
| bus_mode | input | 3 | 0 general-purpose, 1 demux 8, 2 demux 16, 3 mux 8, 4 mux 16 |
| bc_oe | input | 1 | Bus controller drive request for owned pins |
| alt_addr_phase | input | 1 | 1 while the bus controller presents an address |
| alt_dout | input | 16 | Bus controller address or data to drive |
| alt_din | output | 16 | Pin values passed to the bus controller |
| pad_in | input | 16 | Pad input values |
| pad_out | output | 16 | Pad drive values (latch contents) |
| pad_oe | output | 16 | Pad output enables, 1 = drive |

## Verification
The lane assertions take for granted that bus_mode, bc_oe and alt_addr_phase stay stable during a clock period and change only between edges. They also take for granted that ownership changes only through bus_mode, so that an owned lane either reloads from alt_dout or holds its value. The stimulus changes every input away from the rising edge and draws bus_mode over all eight codes. Because of this, entry into and exit from every layout, as well as the unused codes, occur many times. Latch writes are issued in every mode, so dropped writes and partly accepted writes both show up.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    MODE_GPIO  = 3'd0,
    MODE_DMX8  = 3'd1,
    MODE_DMX16 = 3'd2,
    MODE_MUX8  = 3'd3,
    MODE_MUX16 = 3'd4
  } bus_mode_e;

  // lane taken by the bus controller in this layout
  function automatic logic lane_owned(input logic [2:0] mode, input int lane);
    case (mode)
      MODE_DMX8:                         return (lane == 0);
      MODE_DMX16, MODE_MUX8, MODE_MUX16: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // upper lane in 8-bit multiplexed layout keeps the address byte
  function automatic logic lane_addr_only(input logic [2:0] mode, input int lane);
    return (mode == MODE_MUX8) && (lane != 0);
  endfunction

  function automatic logic lane_loads(input logic [2:0] mode, input int lane,
                                      input logic addr_phase);
    return lane_owned(mode, lane) && (!lane_addr_only(mode, lane) || addr_phase);
  endfunction
endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = STAGES * W;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << W) | {{(CW - W){1'b0}}, d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/bpc_lane.sv
module bpc_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         owned,
  input  logic         load_alt,
  input  logic         force_oe,
  input  logic         sw_lat_we,
  input  logic         sw_dir_we,
  input  logic [W-1:0] sw_wdata,
  input  logic [W-1:0] alt_byte,
  input  logic         bc_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] dir_val
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;
  logic         lat_en;

  // latch input multiplexer: bus path while owned, register path otherwise
  always_comb begin
    lat_en = owned ? load_alt : sw_lat_we;
    lat_d  = owned ? alt_byte : sw_wdata;
    dir_d  = sw_dir_we ? sw_wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      if (lat_en) lat_q <= lat_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    if (!owned)       pad_oe = dir_q;
    else if (force_oe) pad_oe = '1;
    else              pad_oe = {W{bc_oe}};
  end

  assign pad_out = lat_q;
  assign dir_val = dir_q;

  p_bus_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && load_alt) |=> (pad_out == $past(alt_byte)));

  p_owned_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !load_alt) |=> $stable(pad_out));

  p_sw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && sw_lat_we) |=> (pad_out == $past(sw_wdata)));

  p_dir_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(owned) && !owned) |-> (pad_oe == dir_val));

  p_addr_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && force_oe) |-> (pad_oe == {W{1'b1}}));
endmodule

// File: rtl/bus_port_ctrl.sv
module bus_port_ctrl
  import bpc_pkg::*;
#(
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_addr,
  input  logic [1:0]             reg_wbe,
  input  logic [2*LANE_W-1:0]    reg_wdata,
  output logic [2*LANE_W-1:0]    reg_rdata,
  output logic                   wr_dropped,
  input  logic [2:0]             bus_mode,
  input  logic                   bc_oe,
  input  logic                   alt_addr_phase,
  input  logic [2*LANE_W-1:0]    alt_dout,
  output logic [2*LANE_W-1:0]    alt_din,
  input  logic [2*LANE_W-1:0]    pad_in,
  output logic [2*LANE_W-1:0]    pad_out,
  output logic [2*LANE_W-1:0]    pad_oe
);
  localparam int LANES = 2;
  localparam int PW    = LANES * LANE_W;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_ff;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  logic [LANES-1:0] own_mask;
  logic [PW-1:0]    dir_all;
  logic [PW-1:0]    pin_sync;
  logic             lat_wr, dir_wr;
  logic             drop_d, drop_q;

  assign lat_wr = reg_wr && !reg_addr;
  assign dir_wr = reg_wr &&  reg_addr;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    localparam int LO = gl * LANE_W;

    assign own_mask[gl] = lane_owned(bus_mode, gl);

    bpc_lane #(.W(LANE_W)) lane_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .owned     (own_mask[gl]),
      .load_alt  (lane_loads(bus_mode, gl, alt_addr_phase)),
      .force_oe  (lane_addr_only(bus_mode, gl)),
      .sw_lat_we (lat_wr && reg_wbe[gl]),
      .sw_dir_we (dir_wr && reg_wbe[gl]),
      .sw_wdata  (reg_wdata[LO +: LANE_W]),
      .alt_byte  (alt_dout[LO +: LANE_W]),
      .bc_oe     (bc_oe),
      .pad_out   (pad_out[LO +: LANE_W]),
      .pad_oe    (pad_oe[LO +: LANE_W]),
      .dir_val   (dir_all[LO +: LANE_W])
    );

    assign alt_din[LO +: LANE_W] = own_mask[gl] ? pad_in[LO +: LANE_W] : '0;
  end

  bpc_sync #(.W(PW), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  assign reg_rdata = reg_addr ? dir_all : pin_sync;

  always_comb begin
    drop_d = lat_wr && ((reg_wbe & own_mask) != '0);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) drop_q <= 1'b0;
    else             drop_q <= drop_d;
  end

  assign wr_dropped = drop_q;

  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lat_wr && ((reg_wbe & own_mask) != '0)) |=> wr_dropped);

  p_drop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lat_wr) |=> !wr_dropped);

  p_gpio_modes_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_mode > 3'd4) |-> (alt_din == '0 && pad_oe == dir_all));
endmodule

// File: tb/bus_port_ctrl_tb_top.sv
module bus_port_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_addr, bc_oe, alt_addr_phase;
  logic [1:0]  reg_wbe;
  logic [15:0] reg_wdata, reg_rdata, alt_dout, alt_din, pad_in, pad_out, pad_oe;
  logic        wr_dropped;
  logic [2:0]  bus_mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] m_lat, m_dir, m_s1, m_s2;
  logic        m_drop;
  logic [2:0]  prev_mode;

  always #10 clk = ~clk;

  bus_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wbe(reg_wbe), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_dropped(wr_dropped), .bus_mode(bus_mode), .bc_oe(bc_oe),
    .alt_addr_phase(alt_addr_phase), .alt_dout(alt_dout), .alt_din(alt_din),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic bit owns(input logic [2:0] m, input int l);
    if (m == 3'd1) return (l == 0);
    return (m >= 3'd2 && m <= 3'd4);
  endfunction

  function automatic bit addr_lane(input logic [2:0] m, input int l);
    return (m == 3'd3) && (l == 1);
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R8";
      3'd2: return "R7";
      3'd3: return "R6";
      3'd4: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] exp_oe(input logic [2:0] m, input logic oe,
                                        input logic [15:0] dir);
    logic [15:0] r;
    for (int l = 0; l < 2; l++) begin
      if (!owns(m, l))       r[l*8 +: 8] = dir[l*8 +: 8];
      else if (addr_lane(m, l)) r[l*8 +: 8] = 8'hFF;
      else                   r[l*8 +: 8] = {8{oe}};
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_altin(input logic [2:0] m, input logic [15:0] p);
    logic [15:0] r;
    for (int l = 0; l < 2; l++) r[l*8 +: 8] = owns(m, l) ? p[l*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // inputs are already set (at a falling edge); check, advance model, check registers
  task automatic step();
    #1;
    chk(mode_tag(bus_mode), pad_oe, exp_oe(bus_mode, bc_oe, m_dir));
    chk("R10", alt_din, exp_altin(bus_mode, pad_in));
    chk(reg_addr ? "R4" : "R3", reg_rdata, reg_addr ? m_dir : m_s2);
    m_drop = 1'b0;
    for (int l = 0; l < 2; l++) begin
      if (owns(bus_mode, l)) begin
        if (!addr_lane(bus_mode, l) || alt_addr_phase) m_lat[l*8 +: 8] = alt_dout[l*8 +: 8];
        if (reg_wr && !reg_addr && reg_wbe[l]) m_drop = 1'b1;
      end else if (reg_wr && !reg_addr && reg_wbe[l]) begin
        m_lat[l*8 +: 8] = reg_wdata[l*8 +: 8];
      end
      if (reg_wr && reg_addr && reg_wbe[l]) m_dir[l*8 +: 8] = reg_wdata[l*8 +: 8];
    end
    m_s2 = m_s1;
    m_s1 = pad_in;
    prev_mode = bus_mode;
    @(negedge clk);
    chk(mode_tag(prev_mode), pad_out, m_lat);
    chk("R9", {15'd0, wr_dropped}, {15'd0, m_drop});
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst_n = 1'b0; reg_wr = 0; reg_addr = 1; reg_wbe = 0; reg_wdata = 0;
    bus_mode = 0; bc_oe = 0; alt_addr_phase = 0; alt_dout = 0; pad_in = 0;
    m_lat = 0; m_dir = 0; m_s1 = 0; m_s2 = 0; m_drop = 0; prev_mode = 0;
    repeat (3) @(negedge clk);
    chk("R1", pad_out, 16'h0000);
    chk("R1", pad_oe, 16'h0000);
    chk("R1", reg_rdata, 16'h0000);
    chk("R1", {15'd0, wr_dropped}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", pad_out | pad_oe | reg_rdata, 16'h0000);

    // directed: dropped write in 16-bit multiplexed mode, then pulse ends
    bus_mode = 3'd4; bc_oe = 1; alt_dout = 16'hA5C3;
    reg_wr = 1; reg_addr = 0; reg_wbe = 2'b11; reg_wdata = 16'hFFFF;
    step();
    chk("R9", pad_out, 16'hA5C3);
    chk("R9", {15'd0, wr_dropped}, 16'h0001);
    reg_wr = 0;
    step();
    chk("R9", {15'd0, wr_dropped}, 16'h0000);
    // directed: 8-bit demux, high lane write accepted while low lane dropped
    bus_mode = 3'd1; alt_dout = 16'h1234;
    reg_wr = 1; reg_wbe = 2'b11; reg_wdata = 16'h5A00;
    step();
    chk("R8", pad_out, 16'h5A34);
    chk("R9", {15'd0, wr_dropped}, 16'h0001);
    // directed: 8-bit mux, high lane holds outside address phase
    bus_mode = 3'd3; reg_wr = 0; alt_addr_phase = 1; alt_dout = 16'hBE11;
    step();
    alt_addr_phase = 0; alt_dout = 16'h0022;
    step();
    chk("R6", pad_out, 16'hBE22);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) bus_mode = 3'($urandom_range(7));
      bc_oe          = 1'($urandom);
      alt_addr_phase = 1'($urandom);
      alt_dout       = 16'($urandom);
      pad_in         = 16'($urandom);
      reg_wr         = 1'($urandom);
      reg_addr       = 1'($urandom);
      reg_wbe        = 2'($urandom);
      reg_wdata      = 16'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule